// File: doc/BRIEF.md
# Three-Wire Serial Control Receiver

This block receives write-only configuration traffic from a host controller over three wires: a phase-select line, a serial clock and a serial data line. It runs entirely on the system clock. The three wires pass through synchronizers, and rising edges of the serial clock are found by comparing successive synchronized samples. While the phase line is low, the bytes shifted in are address bytes. While it is high, they are data bytes.

An address byte names a device and a register group. When the device field matches the block's own identifier, the block becomes selected and remembers the group. Every later data byte goes to that group until another address byte arrives. Inside a group, the two top bits of a data byte pick the register and the six low bits carry the value. The configuration fields are the sample-clock ratio, the serial audio input format, the volume code, the de-emphasis choice and the mute flag. They drive the rest of the audio path directly. A one-cycle strobe marks each register write.

Top module: `ctl3w_slave`

## Requirements
- R1: After reset the fields read ratio 2'b10 (256fs), format 3'b000 (I2S), volume 6'd0, de-emphasis 2'b00 and mute 0, and no update strobe is raised. The block starts deselected, so data bytes are ignored until a matching address byte arrives.
- R2: `ctl_mode_i` low marks address bytes and high marks data bytes. Bits are taken on synchronized rising edges of `ctl_clk_i`, least significant bit first. A byte acts only once its eighth bit has arrived. A change on `ctl_mode_i` discards any partly received byte.
- R3: An address byte with bits 7:2 equal to `DEV_ID` (default 6'b000101) selects the block. Any other value in bits 7:2 deselects it, and data bytes are then ignored.
- R4: Address bits 1:0 pick the group: 2'b00 is the audio group (volume, de-emphasis, mute) and 2'b10 is the setup group (ratio, format). With 2'b01 or 2'b11, every data byte is ignored.
- R5: Selection and group persist over any number of data bytes until the next complete address byte.
- R6: Setup-group register 2'b00 (data bits 7:6) holds the ratio in bits 5:4. The codes are 00 = 512fs, 01 = 384fs and 10 = 256fs. Code 11 leaves the ratio unchanged.
- R7: The same register holds the format in bits 3:1. The codes are 000 I2S, 001/010/011 LSB-justified 16/18/20 bit and 100 MSB-justified. Codes 101 to 111 leave the format unchanged.
- R8: Audio-group register 2'b00 loads the volume code from bits 5:0.
- R9: Audio-group register 2'b10 loads de-emphasis from bits 4:3 (00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz) and mute from bit 2.
- R10: Data bytes that target the other registers change no field and raise no strobe. In the setup group these are registers 01, 10 and 11. In the audio group they are 01 and 11.
- R11: `upd_o` pulses for exactly one cycle, in the cycle the fields take a new write, for each data byte that reaches an implemented register. Fields never change while `upd_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_mode_i | input | 1 | Phase line: low address, high data |
| ctl_clk_i | input | 1 | Serial control clock |
| ctl_dat_i | input | 1 | Serial control data |
| clk_ratio_o | output | 2 | System-clock to sample-rate ratio code |
| fmt_o | output | 3 | Serial audio input format code |
| vol_o | output | 6 | Volume attenuation code |
| deemph_o | output | 2 | De-emphasis selection |
| mute_o | output | 1 | Mute enable |
| upd_o | output | 1 | One-cycle register write strobe |

## Verification
Data bytes are sent before any address, after a matching address, after a foreign identifier and after each unused group code. This separates selection from group choice. Byte values whose bit-reversed form differs show whether bits arrive least significant first. A byte cut short by a phase change, followed by a whole byte, shows whether partial bytes are dropped or merged. Writes with unused ratio and format codes, together with writes to reserved registers, separate per-field filtering from whole-register rejection. A behavioural model compares every output on every clock, which pins down the write latency and the single-cycle strobe.

// File: rtl/ctl3w_pkg.sv
`timescale 1ns/1ps
package ctl3w_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ID_W   = 6;

  typedef enum logic [1:0] {
    GRP_AUDIO  = 2'b00,
    GRP_NONE_A = 2'b01,
    GRP_SETUP  = 2'b10,
    GRP_NONE_B = 2'b11
  } grp_e;

  typedef struct packed {
    logic [1:0] ratio;
    logic [2:0] fmt;
    logic [5:0] vol;
    logic [1:0] deemph;
    logic       mute;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{ratio: 2'b10, fmt: 3'b000, vol: 6'd0,
                                 deemph: 2'b00, mute: 1'b0};

  function automatic logic [ID_W-1:0] addr_id(input logic [BYTE_W-1:0] b);
    return b[7:2];
  endfunction

  function automatic grp_e addr_grp(input logic [BYTE_W-1:0] b);
    return grp_e'(b[1:0]);
  endfunction

  function automatic logic [1:0] reg_pick(input logic [BYTE_W-1:0] b);
    return b[7:6];
  endfunction

  function automatic logic ratio_ok(input logic [1:0] c);
    return c != 2'b11;
  endfunction

  function automatic logic fmt_ok(input logic [2:0] c);
    return c <= 3'd4;
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
`timescale 1ns/1ps
module ctl3w_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctl3w_rx.sv
`timescale 1ns/1ps
module ctl3w_rx import ctl3w_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_s,
  input  logic              sclk_s,
  input  logic              dat_s,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_ph_o,
  output logic              bit_rise_o,
  output logic              mode_chg_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_prev_q, mode_prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              take_bit, last_bit;

  assign bit_rise_o = sclk_s & ~sclk_prev_q;
  assign mode_chg_o = mode_s ^ mode_prev_q;
  assign take_bit   = bit_rise_o & ~mode_chg_o;
  assign last_bit   = take_bit & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      mode_prev_q <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      byte_vld_o  <= 1'b0;
      byte_o      <= '0;
      byte_ph_o   <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      mode_prev_q <= mode_s;
      byte_vld_o  <= last_bit;
      if (mode_chg_o) begin
        cnt_q <= '0;
      end else if (take_bit) begin
        sh_q  <= {dat_s, sh_q[BYTE_W-1:1]};
        cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
      end
      if (last_bit) begin
        byte_o    <= {dat_s, sh_q[BYTE_W-1:1]};
        byte_ph_o <= mode_s;
      end
    end
  end

  // R2
  byte_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> $past(bit_rise_o));
  // R2
  mode_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_o |=> (cnt_q == '0));
  // R2
  byte_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> (byte_ph_o == $past(mode_s)));
endmodule

// File: rtl/ctl3w_regs.sv
`timescale 1ns/1ps
module ctl3w_regs import ctl3w_pkg::*; #(
  parameter logic [ID_W-1:0] DEV_ID = 6'b000101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_ph_i,
  output cfg_t              cfg_o,
  output logic              upd_o
);
  logic       sel_q;
  grp_e       grp_q;
  cfg_t       cfg_q;
  logic       upd_q;
  logic       addr_hit, data_hit;
  logic [1:0] rsel;
  logic       wr_setup, wr_vol, wr_fx, wr_any;

  assign addr_hit = byte_vld_i & ~byte_ph_i;
  assign data_hit = byte_vld_i &  byte_ph_i & sel_q;
  assign rsel     = reg_pick(byte_i);
  assign wr_setup = data_hit && (grp_q == GRP_SETUP) && (rsel == 2'b00);
  assign wr_vol   = data_hit && (grp_q == GRP_AUDIO) && (rsel == 2'b00);
  assign wr_fx    = data_hit && (grp_q == GRP_AUDIO) && (rsel == 2'b10);
  assign wr_any   = wr_setup | wr_vol | wr_fx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      grp_q <= GRP_AUDIO;
      cfg_q <= CFG_RESET;
      upd_q <= 1'b0;
    end else begin
      upd_q <= wr_any;
      if (addr_hit) begin
        sel_q <= (addr_id(byte_i) == DEV_ID);
        grp_q <= addr_grp(byte_i);
      end
      if (wr_setup) begin
        if (ratio_ok(byte_i[5:4])) cfg_q.ratio <= byte_i[5:4];
        if (fmt_ok(byte_i[3:1]))   cfg_q.fmt   <= byte_i[3:1];
      end
      if (wr_vol) cfg_q.vol <= byte_i[5:0];
      if (wr_fx) begin
        cfg_q.deemph <= byte_i[4:3];
        cfg_q.mute   <= byte_i[2];
      end
    end
  end

  assign cfg_o = cfg_q;
  assign upd_o = upd_q;

  // R6
  ratio_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.ratio != 2'b11);
  // R7
  fmt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.fmt <= 3'd4);
  // R11
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R11
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |-> $stable(cfg_q));
  // R3
  upd_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> $past(sel_q && byte_vld_i && byte_ph_i));
  // R4
  upd_valid_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> ($past(grp_q) == GRP_AUDIO || $past(grp_q) == GRP_SETUP));
endmodule

// File: rtl/ctl3w_slave.sv
`timescale 1ns/1ps
module ctl3w_slave import ctl3w_pkg::*; #(
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [ID_W-1:0] DEV_ID      = 6'b000101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_mode_i,
  input  logic       ctl_clk_i,
  input  logic       ctl_dat_i,
  output logic [1:0] clk_ratio_o,
  output logic [2:0] fmt_o,
  output logic [5:0] vol_o,
  output logic [1:0] deemph_o,
  output logic       mute_o,
  output logic       upd_o
);
  logic [2:0]        wires_s;
  logic              byte_vld, byte_ph, bit_rise, mode_chg;
  logic [BYTE_W-1:0] byte_q;
  cfg_t              cfg;

  ctl3w_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({ctl_mode_i, ctl_clk_i, ctl_dat_i}), .q_o(wires_s));

  ctl3w_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .mode_s(wires_s[2]), .sclk_s(wires_s[1]), .dat_s(wires_s[0]),
    .byte_vld_o(byte_vld), .byte_o(byte_q), .byte_ph_o(byte_ph),
    .bit_rise_o(bit_rise), .mode_chg_o(mode_chg));

  ctl3w_regs #(.DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .byte_vld_i(byte_vld), .byte_i(byte_q), .byte_ph_i(byte_ph),
    .cfg_o(cfg), .upd_o(upd_o));

  assign clk_ratio_o = cfg.ratio;
  assign fmt_o       = cfg.fmt;
  assign vol_o       = cfg.vol;
  assign deemph_o    = cfg.deemph;
  assign mute_o      = cfg.mute;

  // R2
  vld_not_on_mode_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> !$past(mode_chg));
endmodule

// File: tb/ctl3w_slave_bench.sv
`timescale 1ns/1ps
module ctl3w_slave_bench;
  logic clk = 1'b0, rst_n = 1'b0, m = 1'b0, c = 1'b0, d = 1'b0;
  logic [1:0] ratio, deemph;
  logic [2:0] fmt;
  logic [5:0] vol;
  logic mute, upd;
  int checks = 0, failures = 0, upd_cnt = 0;
  bit done = 0;

  ctl3w_slave u_ctl3w_slave (
    .clk(clk), .rst_n(rst_n), .ctl_mode_i(m), .ctl_clk_i(c), .ctl_dat_i(d),
    .clk_ratio_o(ratio), .fmt_o(fmt), .vol_o(vol), .deemph_o(deemph),
    .mute_o(mute), .upd_o(upd));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [2:0] hist[$];
  logic [2:0] now_s, old_s;
  int mcnt, mgrp, e_ratio, e_fmt, e_vol, e_deemph, e_mute, e_upd;
  logic [7:0] mbits, pbyte;
  bit pend, pph, msel;

  task automatic model_reset();
    hist.delete(); mcnt = 0; pend = 0; msel = 0; mgrp = 0;
    e_ratio = 2; e_fmt = 0; e_vol = 0; e_deemph = 0; e_mute = 0; e_upd = 0;
  endtask

  task automatic model_decode(input int b, input bit ph);
    int r;
    r = b / 64;
    if (!ph) begin
      msel = ((b / 4) == 5);
      mgrp = b % 4;
    end else if (msel) begin
      if (mgrp == 2 && r == 0) begin
        e_upd = 1;
        if (((b / 16) % 4) != 3) e_ratio = (b / 16) % 4;
        if (((b / 2) % 8) < 5)   e_fmt   = (b / 2) % 8;
      end else if (mgrp == 0 && r == 0) begin
        e_upd = 1; e_vol = b % 64;
      end else if (mgrp == 0 && r == 2) begin
        e_upd = 1; e_deemph = (b / 8) % 4; e_mute = (b / 4) % 2;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      e_upd = 0;
      if (pend) begin model_decode(int'(pbyte), pph); pend = 0; end
      hist.push_back({m, c, d});
      if (hist.size() > 4) void'(hist.pop_front());
      if (hist.size() == 4) begin
        now_s = hist[1]; old_s = hist[0];
        if (now_s[2] != old_s[2]) mcnt = 0;
        else if (now_s[1] && !old_s[1]) begin
          mbits[mcnt] = now_s[0];
          mcnt++;
          if (mcnt == 8) begin pend = 1; pbyte = mbits; pph = now_s[2]; mcnt = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd) upd_cnt++;
      chk("R6 ratio vs model", int'(ratio), e_ratio);
      chk("R7 format vs model", int'(fmt), e_fmt);
      chk("R8 volume vs model", int'(vol), e_vol);
      chk("R9 de-emphasis vs model", int'(deemph), e_deemph);
      chk("R9 mute vs model", int'(mute), e_mute);
      chk("R11 strobe vs model", int'(upd), e_upd);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input bit ph, input logic [7:0] b, input int n);
    m = ph; c = 0; d = 0;
    wait_cyc(4);
    for (int i = 0; i < n; i++) begin
      d = b[i]; wait_cyc(4);
      c = 1;    wait_cyc(4);
      c = 0;
    end
    wait_cyc(8);
  endtask

  task automatic send_byte(input bit ph, input logic [7:0] b);
    send_bits(ph, b, 8);
  endtask

  task automatic do_reset();
    m = 0; c = 0; d = 0;
    wait_cyc(4);
    rst_n = 0; wait_cyc(4); rst_n = 1; wait_cyc(4);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int base;
    rst_n = 0; wait_cyc(5);
    chk("R1 reset ratio", int'(ratio), 2);
    chk("R1 reset format", int'(fmt), 0);
    chk("R1 reset volume", int'(vol), 0);
    chk("R1 reset de-emphasis", int'(deemph), 0);
    chk("R1 reset mute", int'(mute), 0);
    chk("R1 reset strobe", int'(upd), 0);
    rst_n = 1; wait_cyc(4);

    // R1: deselected out of reset
    send_byte(1, 8'h2A);
    chk("R1 data ignored before address", int'(vol), 0);

    // R3, R8, R2: LSB-first volume write
    send_byte(0, 8'h14);
    base = upd_cnt;
    send_byte(1, 8'h2A);
    chk("R8 volume 0x2A (R2 bit order)", int'(vol), 42);
    chk("R11 one strobe per write", upd_cnt - base, 1);
    // R9
    send_byte(1, 8'h94);
    chk("R9 de-emphasis 44.1k", int'(deemph), 2);
    chk("R9 mute set", int'(mute), 1);
    // R5: still selected
    send_byte(1, 8'h05);
    chk("R5 selection persists", int'(vol), 5);

    // R6, R7 setup group
    send_byte(0, 8'h16);
    send_byte(1, 8'h16);
    chk("R6 ratio 384fs", int'(ratio), 1);
    chk("R7 format LSB20", int'(fmt), 3);
    send_byte(1, 8'h38);
    chk("R6 unused ratio code keeps value", int'(ratio), 1);
    chk("R7 MSB-justified", int'(fmt), 4);
    send_byte(1, 8'h0E);
    chk("R6 ratio 512fs", int'(ratio), 0);
    chk("R7 unused format code keeps value", int'(fmt), 4);
    chk("R8 volume untouched by setup group", int'(vol), 5);

    // R10 reserved registers
    base = upd_cnt;
    send_byte(1, 8'h7F);
    send_byte(1, 8'hBF);
    send_byte(1, 8'hC1);
    send_byte(0, 8'h14);
    send_byte(1, 8'h7F);
    send_byte(1, 8'hC1);
    chk("R10 no strobe on reserved registers", upd_cnt - base, 0);
    chk("R10 volume unchanged", int'(vol), 5);
    chk("R10 ratio unchanged", int'(ratio), 0);

    // R3 foreign identifier
    send_byte(0, 8'h18);
    send_byte(1, 8'h11);
    chk("R3 foreign id ignores data", int'(vol), 5);

    // R4 unused groups
    base = upd_cnt;
    send_byte(0, 8'h15);
    send_byte(1, 8'h11);
    send_byte(1, 8'h80);
    send_byte(0, 8'h17);
    send_byte(1, 8'h11);
    send_byte(1, 8'h00);
    chk("R4 unused group volume", int'(vol), 5);
    chk("R4 unused group mute", int'(mute), 1);
    chk("R4 unused group strobe count", upd_cnt - base, 0);

    // R2 partial byte dropped on mode change
    send_byte(0, 8'h14);
    send_bits(1, 8'h3F, 5);
    m = 0; wait_cyc(8);
    send_byte(1, 8'h09);
    chk("R2 partial byte discarded", int'(vol), 9);
    // R2 partial address dropped, selection kept (R5)
    send_bits(0, 8'h18, 5);
    send_byte(1, 8'h21);
    chk("R5 partial address keeps selection", int'(vol), 33);

    // R1 reset mid-run
    do_reset();
    chk("R1 volume after second reset", int'(vol), 0);
    chk("R1 mute after second reset", int'(mute), 0);
    send_byte(1, 8'h2A);
    chk("R1 deselected after second reset", int'(vol), 0);

    wait_cyc(10);
    done = 1;
    finish_run();
  end
endmodule